// File: doc/BRIEF.md
# Two-Counter Bit Stack

This block keeps a stack of single bits inside one binary counter. The stack is the number held in the primary counter, and the top entry is its least significant bit. A second counter of the same width serves as scratch. Every command is carried out with only three counter primitives: add one, subtract one, and test for zero. No shifter, adder or memory touches the stack.

A push doubles the stored number and, for a one, adds one. It does this by moving the primary into the scratch, two increments for each decrement. A pop halves the number. It decrements the primary twice for each increment of the scratch, and the parity of the single decrements gives the popped bit. When a loop ends, the two counters swap roles, so no copy-back loop is needed and the scratch reads zero whenever the block is idle.

A command is offered on a valid/ready pair. The block reports `busy` while it works and pulses `done` when it finishes, together with the popped bit and an overflow flag.

Top module: `ctr_bitstack`

## Requirements
- R1: After reset the block is idle: `cmd_ready` and `stack_empty` are 1, and `done`, `busy`, `overflow` and `result_bit` are 0.
- R2: A command is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both 1. `busy` is 1 from that edge until the cycle after `done`. `cmd_ready` equals the inverse of `busy`. `done` is high for exactly one cycle, and only while `busy` is high.
- R3: Stack contents follow the number V in the primary counter. Push (`cmd_push`=1) with bit b sets V to 2V+b. Pop (`cmd_push`=0) returns V mod 2 on `result_bit` during `done` and sets V to floor(V/2). Pushed bits therefore come back in reverse order, and `result_bit` is 0 for a push. Zeros pushed beneath the lowest one are lost, so pushing 0 onto an empty stack leaves it empty.
- R4: A push that does not overflow raises `done` in the cycle that begins 3V+1+b rising edges after the accepting edge, where V is the value before the push.
- R5: A pop raises `done` in the cycle that begins 3*floor(V/2)+1+(V mod 2) rising edges after the accepting edge.
- R6: A pop on an empty stack (V=0) returns bit 0, leaves the stack empty, does not raise `overflow`, and completes after 1 edge, as R5 gives.
- R7: A push whose result 2V+b exceeds 2^WIDTH-1 is aborted. `overflow` rises with `done` in the cycle that begins 3*2^(WIDTH-1)+1 edges after acceptance. The stack is emptied, and `overflow` stays 1 until the next command is accepted.
- R8: While `busy` is 1, `cmd_valid`, `cmd_push` and `cmd_bit` have no effect. Only the accepted command changes the stack.
- R9: `stack_empty` is 1 exactly when the block is idle and V is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can take a command (inverse of busy) |
| cmd_push | input | 1 | 1 = push, 0 = pop |
| cmd_bit | input | 1 | Bit to push; ignored for a pop |
| busy | output | 1 | A command is being executed |
| done | output | 1 | One-cycle completion pulse |
| result_bit | output | 1 | Popped bit, valid with done and held until the next done |
| overflow | output | 1 | Last push was aborted because an increment would wrap |
| stack_empty | output | 1 | Idle and the stack value is zero |

## Verification
The bench builds the block with WIDTH set to 4, so the stack value tops out at 15. Overflow is then reachable after a handful of pushes, and the longest command takes about 25 cycles. Short runs therefore cover filling the stack, the push that overflows at the wrap boundary, pushes of zero onto an empty stack, and draining the stack to empty. Every command's latency is checked against the closed-form counts of R4, R5 and R7.

// File: rtl/ctr_bitstack_pkg.sv
package ctr_bitstack_pkg;

  // Sequencer states; each state applies at most one counter primitive.
  typedef enum logic [3:0] {
    ST_IDLE     = 4'd0,
    ST_DBL_TEST = 4'd1,
    ST_DBL_INCA = 4'd2,
    ST_DBL_INCB = 4'd3,
    ST_SET_LSB  = 4'd4,
    ST_HLF_TST1 = 4'd5,
    ST_HLF_TST2 = 4'd6,
    ST_HLF_INC  = 4'd7,
    ST_ABORT    = 4'd8,
    ST_FIN      = 4'd9
  } seq_state_e;

  localparam int NUM_CTRS = 2;

endpackage

// File: rtl/ctr_rst_sync.sv
module ctr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/ctr_unit.sv
// One counter register restricted to the primitives: +1, -1 (saturating
// at zero) and a zero test. A wrap detector and a synchronous clear are
// used only for abort handling.
module ctr_unit #(
  parameter int WIDTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  input  logic clr,
  output logic is_zero,
  output logic is_max
);

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clr) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (inc && !is_max) begin
      cnt_d  = cnt_q + WIDTH'(1);
      cnt_en = 1'b1;
    end else if (dec && !is_zero) begin
      cnt_d  = cnt_q - WIDTH'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign is_zero = (cnt_q == '0);
  assign is_max  = &cnt_q;

endmodule

// File: rtl/ctr_seq.sv
// Command sequencer: drives one primitive per cycle on the primary or
// scratch counter and swaps their roles when a loop finishes.
module ctr_seq
  import ctr_bitstack_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_fire,
  input  logic cmd_push,
  input  logic cmd_bit,
  input  logic p_zero,
  input  logic s_max,
  output logic busy,
  output logic done,
  output logic p_dec,
  output logic s_inc,
  output logic clr_all,
  output logic sel,
  output logic result_bit,
  output logic overflow
);

  seq_state_e state_q, state_d;
  logic       sel_q, sel_d;
  logic       pbit_q, pbit_d;
  logic       ovf_q, ovf_d;
  logic       res_q, res_d;

  always_comb begin
    state_d = state_q;
    sel_d   = sel_q;
    pbit_d  = pbit_q;
    ovf_d   = ovf_q;
    res_d   = res_q;
    p_dec   = 1'b0;
    s_inc   = 1'b0;
    clr_all = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_fire) begin
          ovf_d   = 1'b0;
          pbit_d  = cmd_bit;
          state_d = cmd_push ? ST_DBL_TEST : ST_HLF_TST1;
        end
      end
      // Doubling loop: one decrement of the primary, two increments of scratch.
      ST_DBL_TEST: begin
        if (p_zero) begin
          if (pbit_q) begin
            state_d = ST_SET_LSB;
          end else begin
            sel_d   = ~sel_q;
            res_d   = 1'b0;
            state_d = ST_FIN;
          end
        end else begin
          p_dec   = 1'b1;
          state_d = ST_DBL_INCA;
        end
      end
      ST_DBL_INCA: begin
        if (s_max) begin
          state_d = ST_ABORT;
        end else begin
          s_inc   = 1'b1;
          state_d = ST_DBL_INCB;
        end
      end
      ST_DBL_INCB: begin
        if (s_max) begin
          state_d = ST_ABORT;
        end else begin
          s_inc   = 1'b1;
          state_d = ST_DBL_TEST;
        end
      end
      ST_SET_LSB: begin
        if (s_max) begin
          state_d = ST_ABORT;
        end else begin
          s_inc   = 1'b1;
          sel_d   = ~sel_q;
          res_d   = 1'b0;
          state_d = ST_FIN;
        end
      end
      // Halving loop: two decrements of the primary, one increment of scratch.
      ST_HLF_TST1: begin
        if (p_zero) begin
          sel_d   = ~sel_q;
          res_d   = 1'b0;
          state_d = ST_FIN;
        end else begin
          p_dec   = 1'b1;
          state_d = ST_HLF_TST2;
        end
      end
      ST_HLF_TST2: begin
        if (p_zero) begin
          sel_d   = ~sel_q;
          res_d   = 1'b1;
          state_d = ST_FIN;
        end else begin
          p_dec   = 1'b1;
          state_d = ST_HLF_INC;
        end
      end
      ST_HLF_INC: begin
        if (s_max) begin
          state_d = ST_ABORT;
        end else begin
          s_inc   = 1'b1;
          state_d = ST_HLF_TST1;
        end
      end
      ST_ABORT: begin
        clr_all = 1'b1;
        sel_d   = 1'b0;
        ovf_d   = 1'b1;
        res_d   = 1'b0;
        state_d = ST_FIN;
      end
      ST_FIN: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= 1'b0;
      pbit_q  <= 1'b0;
      ovf_q   <= 1'b0;
      res_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
      pbit_q  <= pbit_d;
      ovf_q   <= ovf_d;
      res_q   <= res_d;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign done       = (state_q == ST_FIN);
  assign sel        = sel_q;
  assign result_bit = res_q;
  assign overflow   = ovf_q;

endmodule

// File: rtl/ctr_bitstack.sv
module ctr_bitstack
  import ctr_bitstack_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  output logic cmd_ready,
  input  logic cmd_push,
  input  logic cmd_bit,
  output logic busy,
  output logic done,
  output logic result_bit,
  output logic overflow,
  output logic stack_empty
);

  logic                rst_q;
  logic [NUM_CTRS-1:0] c_inc;
  logic [NUM_CTRS-1:0] c_dec;
  logic [NUM_CTRS-1:0] c_zero;
  logic [NUM_CTRS-1:0] c_max;
  logic                p_dec;
  logic                s_inc;
  logic                clr_all;
  logic                sel;
  logic                p_zero;
  logic                s_zero;
  logic                s_max;
  logic                cmd_fire;

  ctr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q)
  );

  // The role pointer picks which counter is primary; the other is scratch.
  for (genvar i = 0; i < NUM_CTRS; i++) begin : g_ctr
    assign c_dec[i] = p_dec & (sel == 1'(i));
    assign c_inc[i] = s_inc & (sel != 1'(i));
    ctr_unit #(.WIDTH(WIDTH)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_q),
      .inc     (c_inc[i]),
      .dec     (c_dec[i]),
      .clr     (clr_all),
      .is_zero (c_zero[i]),
      .is_max  (c_max[i])
    );
  end

  assign p_zero = sel ? c_zero[1] : c_zero[0];
  assign s_zero = sel ? c_zero[0] : c_zero[1];
  assign s_max  = sel ? c_max[0]  : c_max[1];

  assign cmd_ready = rst_q & ~busy;
  assign cmd_fire  = cmd_valid & cmd_ready;

  ctr_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_q),
    .cmd_fire   (cmd_fire),
    .cmd_push   (cmd_push),
    .cmd_bit    (cmd_bit),
    .p_zero     (p_zero),
    .s_max      (s_max),
    .busy       (busy),
    .done       (done),
    .p_dec      (p_dec),
    .s_inc      (s_inc),
    .clr_all    (clr_all),
    .sel        (sel),
    .result_bit (result_bit),
    .overflow   (overflow)
  );

  assign stack_empty = ~busy & p_zero;

endmodule

// File: rtl/ctr_bitstack_chk.sv
module ctr_bitstack_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       busy,
  input logic       done,
  input logic       overflow,
  input logic       p_dec,
  input logic       s_inc,
  input logic       clr_all,
  input logic       s_zero,
  input logic [1:0] c_dec,
  input logic [1:0] c_zero
);

  // R2: an accepted command makes the block busy on the next cycle
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy);

  // R2: done only while busy, and busy drops right after done
  p_done_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  p_done_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R7: overflow can only rise together with the completion pulse
  p_ovf_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> done);

  // R3: the scratch counter is empty whenever the block is idle
  p_scratch_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> s_zero);

  // R3: at most one counter primitive per cycle
  p_one_prim_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({p_dec, s_inc, clr_all}));

  // R6: a decrement at zero leaves the counter at zero
  p_dec_sat0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (c_dec[0] && c_zero[0]) |=> c_zero[0]);
  p_dec_sat1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (c_dec[1] && c_zero[1]) |=> c_zero[1]);

endmodule

bind ctr_bitstack ctr_bitstack_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .busy      (busy),
  .done      (done),
  .overflow  (overflow),
  .p_dec     (p_dec),
  .s_inc     (s_inc),
  .clr_all   (clr_all),
  .s_zero    (s_zero),
  .c_dec     (c_dec),
  .c_zero    (c_zero)
);

// File: tb/ctr_bitstack_test.sv
module ctr_bitstack_test;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 4;
  localparam int MAXV       = (1 << W) - 1;

  logic clk;
  logic rst_n;
  logic cmd_valid;
  logic cmd_ready;
  logic cmd_push;
  logic cmd_bit;
  logic busy;
  logic done;
  logic result_bit;
  logic overflow;
  logic stack_empty;

  int n_tests;
  int n_fail;
  int model_val;
  int model_ovf;
  int model_res;

  ctr_bitstack #(.WIDTH(W)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_push    (cmd_push),
    .cmd_bit     (cmd_bit),
    .busy        (busy),
    .done        (done),
    .result_bit  (result_bit),
    .overflow    (overflow),
    .stack_empty (stack_empty)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Issue one command; compare every cycle against the behavioural model.
  task automatic run_cmd(input bit push, input bit b, input bit hold);
    int    lat;
    int    nv;
    int    exp_res;
    int    exp_ovf;
    string tag;
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_push  = push;
    cmd_bit   = b;
    if (push) begin
      nv = 2 * model_val + int'(b);
      if (nv > MAXV) begin
        lat = 3 * ((MAXV + 1) / 2) + 1;
        nv = 0; exp_res = 0; exp_ovf = 1; tag = "R7";
      end else begin
        lat = 3 * model_val + 1 + int'(b);
        exp_res = 0; exp_ovf = 0; tag = "R4";
      end
    end else begin
      lat = 3 * (model_val / 2) + 1 + (model_val % 2);
      exp_res = model_val % 2;
      nv = model_val / 2; exp_ovf = 0;
      tag = (model_val == 0) ? "R6" : "R5";
    end
    @(posedge clk);
    @(negedge clk);
    if (!hold) cmd_valid = 1'b0;
    for (int i = 0; i <= lat; i++) begin
      check("R2 busy", int'(busy), 1);
      check("R2 ready", int'(cmd_ready), 0);
      check({tag, " done timing"}, int'(done), (i == lat) ? 1 : 0);
      if (hold) begin
        cmd_push = ~cmd_push;
        cmd_bit  = ~cmd_bit;
      end
      if (i == lat) begin
        check({"R3 result ", tag}, int'(result_bit), exp_res);
        check({"R7 overflow ", tag}, int'(overflow), exp_ovf);
        cmd_valid = 1'b0;
      end
      @(negedge clk);
    end
    model_val = nv;
    model_ovf = exp_ovf;
    model_res = exp_res;
    check(hold ? "R8 idle after held valid" : "R2 idle", int'(busy), 0);
    check("R2 done pulse", int'(done), 0);
    check("R9 empty", int'(stack_empty), (model_val == 0) ? 1 : 0);
    check("R7 overflow held", int'(overflow), model_ovf);
    check("R3 result held", int'(result_bit), model_res);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_tests = 0; n_fail = 0; model_val = 0; model_ovf = 0; model_res = 0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_push = 1'b0; cmd_bit = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 ready", int'(cmd_ready), 1);
    check("R1 empty", int'(stack_empty), 1);
    check("R1 done", int'(done), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 overflow", int'(overflow), 0);
    check("R1 result", int'(result_bit), 0);

    // R6: pop on empty
    run_cmd(1'b0, 1'b0, 1'b0);
    // R3/R9: push 0 onto empty stays empty
    run_cmd(1'b1, 1'b0, 1'b0);
    // R3/R4/R5: push 1,0,1,1 then pop four, reverse order
    run_cmd(1'b1, 1'b1, 1'b0);
    run_cmd(1'b1, 1'b0, 1'b0);
    run_cmd(1'b1, 1'b1, 1'b0);
    run_cmd(1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 4; k++) run_cmd(1'b0, 1'b0, 1'b0);
    run_cmd(1'b0, 1'b0, 1'b0);

    // R8: valid held and inputs toggled while busy
    run_cmd(1'b1, 1'b1, 1'b1);
    run_cmd(1'b1, 1'b0, 1'b1);
    run_cmd(1'b0, 1'b1, 1'b1);
    run_cmd(1'b0, 1'b0, 1'b0);
    run_cmd(1'b0, 1'b0, 1'b0);

    // R7: fill to 15 without overflow, then overflow
    for (int k = 0; k < 4; k++) run_cmd(1'b1, 1'b1, 1'b0);
    run_cmd(1'b1, 1'b0, 1'b0);
    // overflow clears on next accept (R7), stack emptied
    run_cmd(1'b0, 1'b1, 1'b0);
    // R7: value 8 then push 0 overflows; value 7 then push 1 does not
    run_cmd(1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 3; k++) run_cmd(1'b1, 1'b0, 1'b0);
    run_cmd(1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) run_cmd(1'b1, 1'b1, 1'b0);
    run_cmd(1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 5; k++) run_cmd(1'b0, 1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule